// File: doc/BRIEF.md
# Chunk ECC Status Reducer

This block folds a stream of one-byte per-chunk ECC status codes into page-level figures. While a page is being read back, each chunk's status code arrives with a valid strobe. A page-start marker opens a new page and a page-end marker closes it. One cycle after the page-end marker, the block presents four results and pulses a result strobe:

- the largest number of bits corrected in any single chunk;
- the total number of corrected bits across the page;
- the number of chunks that could not be corrected;
- a flag that marks the page as failed.

The status byte uses a fixed encoding:

- Zero means a clean chunk.
- 0xFF marks an erased chunk.
- 0xFE marks an uncorrectable chunk.
- A value from 1 to a correction ceiling (40 by default) is the number of bits corrected in that chunk.
- Any other value above the ceiling is also treated as uncorrectable.

The calling logic checks the failure flag first. When the flag is clear, the maximum per-chunk count is the figure it uses for wear decisions.

Top module: `chunk_status_reducer`

## Requirements
- R1: While reset is high, and in the first cycle after reset releases, `res_valid_o`, `max_flips_o`, `total_corr_o`, `fail_cnt_o` and `page_fail_o` are all zero.
- R2: A status of 0x00 leaves the maximum, the total and the failure count unchanged.
- R3: A status of 0xFF (erased) changes none of the page figures.
- R4: A status of 0xFE adds one to the uncorrectable-chunk count.
- R5: Any status from 0x29 to 0xFD adds one to the uncorrectable-chunk count. It adds nothing to the total or the maximum.
- R6: A status from 0x01 to 0x28 adds its value to the total. It raises the maximum when the value is larger than the current maximum. `max_flips_o` never exceeds 0x28.
- R7: `page_fail_o` is high exactly when the reported uncorrectable-chunk count is non-zero.
- R8: The corrected total saturates at 0xFFFF instead of wrapping.
- R9: Page start clears all accumulators. A status presented in the same cycle as page start counts toward the new page.
- R10: A status presented with page end is included in that page. `res_valid_o` is high for exactly the one cycle after page end. The result outputs hold their values until the next page end.
- R11: The uncorrectable-chunk count saturates at its all-ones value (255 by default).
- R12: A status byte presented while `st_valid_i` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_start_i | input | 1 | Opens a new page; clears the accumulators |
| page_end_i | input | 1 | Closes the page; results follow one cycle later |
| st_valid_i | input | 1 | Status byte on `st_byte_i` is valid |
| st_byte_i | input | 8 | Per-chunk ECC status code |
| res_valid_o | output | 1 | One-cycle strobe marking fresh results |
| max_flips_o | output | 8 | Largest per-chunk corrected count in the page |
| total_corr_o | output | 16 | Saturating sum of corrected bits in the page |
| fail_cnt_o | output | 8 | Saturating count of uncorrectable chunks |
| page_fail_o | output | 1 | High when at least one chunk was uncorrectable |

## Verification
The functions most likely to collide are opening a page and closing one. A chunk's status can arrive in the very cycle that clears the accumulators, and again in the very cycle that latches the results. The bench provokes both by driving a single-chunk page, with start, end and a valid status all in one cycle. It also places the last status of a page on the end marker. A behavioural model updates every clock and is compared against each output every cycle. Directed end-of-page checks then confirm that the figures carry neither the previous page's residue nor a missing last chunk.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // Classification of one chunk status code
  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_ERASED = 2'd1,
    CLS_FIXED  = 2'd2,
    CLS_BAD    = 2'd3
  } chunk_cls_e;
endpackage

// File: rtl/csr_classify.sv
module csr_classify
  import csr_pkg::*;
#(
  parameter int STAT_W      = 8,
  parameter int MAX_CORR    = 40,
  parameter int ERASED_CODE = 255,
  parameter int UNCORR_CODE = 254
) (
  input  logic [STAT_W-1:0] code_i,
  output chunk_cls_e        cls_o,
  output logic [STAT_W-1:0] flips_o
);
  localparam logic [STAT_W-1:0] ErasedVal = STAT_W'(ERASED_CODE);
  localparam logic [STAT_W-1:0] UncorrVal = STAT_W'(UNCORR_CODE);
  localparam logic [STAT_W-1:0] CeilVal   = STAT_W'(MAX_CORR);

  always_comb begin
    if (code_i == '0)                              cls_o = CLS_CLEAN;
    else if (code_i == ErasedVal)                  cls_o = CLS_ERASED;
    else if (code_i == UncorrVal || code_i > CeilVal) cls_o = CLS_BAD;
    else                                           cls_o = CLS_FIXED;
  end

  assign flips_o = (cls_o == CLS_FIXED) ? code_i : '0;
endmodule

// File: rtl/csr_accum.sv
module csr_accum
  import csr_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int SUM_W  = 16,
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              add_i,
  input  chunk_cls_e        cls_i,
  input  logic [STAT_W-1:0] flips_i,
  output logic [STAT_W-1:0] nxt_max_o,
  output logic [SUM_W-1:0]  nxt_sum_o,
  output logic [FAIL_W-1:0] nxt_fail_o
);
  localparam logic [SUM_W-1:0]  SumMax  = {SUM_W{1'b1}};
  localparam logic [FAIL_W-1:0] FailMax = {FAIL_W{1'b1}};

  logic [STAT_W-1:0] acc_max;
  logic [SUM_W-1:0]  acc_sum;
  logic [FAIL_W-1:0] acc_fail;

  logic [STAT_W-1:0] base_max;
  logic [SUM_W-1:0]  base_sum;
  logic [FAIL_W-1:0] base_fail;
  logic [SUM_W:0]    sum_wide;

  always_comb begin
    base_max  = clr_i ? '0 : acc_max;
    base_sum  = clr_i ? '0 : acc_sum;
    base_fail = clr_i ? '0 : acc_fail;
    sum_wide  = {1'b0, base_sum} + {{(SUM_W+1-STAT_W){1'b0}}, flips_i};
    nxt_max_o  = base_max;
    nxt_sum_o  = base_sum;
    nxt_fail_o = base_fail;
    if (add_i) begin
      if (cls_i == CLS_FIXED) begin
        nxt_sum_o = sum_wide[SUM_W] ? SumMax : sum_wide[SUM_W-1:0];
        if (flips_i > base_max) nxt_max_o = flips_i;
      end else if (cls_i == CLS_BAD) begin
        if (base_fail != FailMax) nxt_fail_o = base_fail + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_max  <= '0;
      acc_sum  <= '0;
      acc_fail <= '0;
    end else begin
      acc_max  <= nxt_max_o;
      acc_sum  <= nxt_sum_o;
      acc_fail <= nxt_fail_o;
    end
  end

  // R8: a saturated total stays saturated within the page
  p_sum_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && acc_sum == SumMax) |=> acc_sum == SumMax);

  // R6: within a page the total never decreases
  p_sum_mono_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> acc_sum >= $past(acc_sum));

  // R3: an erased chunk leaves every accumulator untouched
  p_erased_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (add_i && cls_i == CLS_ERASED && !clr_i) |=>
      ($stable(acc_sum) && $stable(acc_max) && $stable(acc_fail)));

  // R11: a failing chunk below saturation adds exactly one
  p_fail_step_r11: assert property (@(posedge clk) disable iff (rst)
    (add_i && cls_i == CLS_BAD && !clr_i && acc_fail != FailMax) |=>
      acc_fail == $past(acc_fail) + 1'b1);
endmodule

// File: rtl/chunk_status_reducer.sv
module chunk_status_reducer
  import csr_pkg::*;
#(
  parameter int STAT_W      = 8,
  parameter int SUM_W       = 16,
  parameter int FAIL_W      = 8,
  parameter int MAX_CORR    = 40,
  parameter int ERASED_CODE = 255,
  parameter int UNCORR_CODE = 254
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_start_i,
  input  logic              page_end_i,
  input  logic              st_valid_i,
  input  logic [STAT_W-1:0] st_byte_i,
  output logic              res_valid_o,
  output logic [STAT_W-1:0] max_flips_o,
  output logic [SUM_W-1:0]  total_corr_o,
  output logic [FAIL_W-1:0] fail_cnt_o,
  output logic              page_fail_o
);
  chunk_cls_e        cls;
  logic [STAT_W-1:0] flips;
  logic [STAT_W-1:0] nxt_max;
  logic [SUM_W-1:0]  nxt_sum;
  logic [FAIL_W-1:0] nxt_fail;

  csr_classify #(
    .STAT_W(STAT_W), .MAX_CORR(MAX_CORR),
    .ERASED_CODE(ERASED_CODE), .UNCORR_CODE(UNCORR_CODE)
  ) u_classify (
    .code_i (st_byte_i),
    .cls_o  (cls),
    .flips_o(flips)
  );

  csr_accum #(
    .STAT_W(STAT_W), .SUM_W(SUM_W), .FAIL_W(FAIL_W)
  ) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (page_start_i),
    .add_i     (st_valid_i),
    .cls_i     (cls),
    .flips_i   (flips),
    .nxt_max_o (nxt_max),
    .nxt_sum_o (nxt_sum),
    .nxt_fail_o(nxt_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o  <= 1'b0;
      max_flips_o  <= '0;
      total_corr_o <= '0;
      fail_cnt_o   <= '0;
      page_fail_o  <= 1'b0;
    end else begin
      res_valid_o <= page_end_i;
      if (page_end_i) begin
        max_flips_o  <= nxt_max;
        total_corr_o <= nxt_sum;
        fail_cnt_o   <= nxt_fail;
        page_fail_o  <= (nxt_fail != '0);
      end
    end
  end

  // R10: result strobe follows page end by exactly one cycle
  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    page_end_i |=> res_valid_o);
  p_nopulse_r10: assert property (@(posedge clk) disable iff (rst)
    !page_end_i |=> !res_valid_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !page_end_i |=> ($stable(total_corr_o) && $stable(max_flips_o) && $stable(fail_cnt_o)));

  // R7: failure flag agrees with the failing-chunk count
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    page_fail_o == (fail_cnt_o != '0));

  // R6: reported maximum stays within the correction ceiling
  p_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
    max_flips_o <= STAT_W'(MAX_CORR));
endmodule

// File: tb/chunk_status_reducer_tb.sv
`timescale 1ns/1ps
module chunk_status_reducer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       page_start_i = 1'b0;
  logic       page_end_i = 1'b0;
  logic       st_valid_i = 1'b0;
  logic [7:0] st_byte_i = 8'h00;
  logic       res_valid_o;
  logic [7:0] max_flips_o;
  logic [15:0] total_corr_o;
  logic [7:0] fail_cnt_o;
  logic       page_fail_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int m_max = 0, m_sum = 0, m_fail = 0;
  int o_max = 0, o_sum = 0, o_fail = 0, o_vld = 0, o_flag = 0;

  always #4 clk = ~clk;

  chunk_status_reducer u_dut (
    .clk(clk), .rst(rst),
    .page_start_i(page_start_i), .page_end_i(page_end_i),
    .st_valid_i(st_valid_i), .st_byte_i(st_byte_i),
    .res_valid_o(res_valid_o), .max_flips_o(max_flips_o),
    .total_corr_o(total_corr_o), .fail_cnt_o(fail_cnt_o),
    .page_fail_o(page_fail_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_max = 0; m_sum = 0; m_fail = 0;
      o_max = 0; o_sum = 0; o_fail = 0; o_vld = 0; o_flag = 0;
    end else begin
      if (page_start_i) begin m_max = 0; m_sum = 0; m_fail = 0; end
      if (st_valid_i) begin
        int b;
        b = int'(st_byte_i);
        if (b == 0 || b == 255) begin end
        else if (b == 254 || b > 40) m_fail = (m_fail >= 255) ? 255 : m_fail + 1;
        else begin
          m_sum = (m_sum + b > 65535) ? 65535 : m_sum + b;
          if (b > m_max) m_max = b;
        end
      end
      o_vld = int'(page_end_i);
      if (page_end_i) begin
        o_max = m_max; o_sum = m_sum; o_fail = m_fail;
        o_flag = (m_fail != 0) ? 1 : 0;
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 valid", int'(res_valid_o), o_vld);
      chk("R6 max", int'(max_flips_o), o_max);
      chk("R8 total", int'(total_corr_o), o_sum);
      chk("R11 fails", int'(fail_cnt_o), o_fail);
      chk("R7 flag", int'(page_fail_o), o_flag);
    end
  end

  task automatic beat(input logic s, input logic e, input logic v, input logic [7:0] b);
    @(negedge clk);
    page_start_i = s; page_end_i = e; st_valid_i = v; st_byte_i = b;
  endtask

  task automatic finish_page(input string req, input int emax, input int esum,
                             input int efail, input int eflag);
    @(negedge clk);
    page_start_i = 0; page_end_i = 0; st_valid_i = 0; st_byte_i = 8'h00;
    chk({req, " strobe"}, int'(res_valid_o), 1);
    chk({req, " max"}, int'(max_flips_o), emax);
    chk({req, " total"}, int'(total_corr_o), esum);
    chk({req, " fails"}, int'(fail_cnt_o), efail);
    chk({req, " flag"}, int'(page_fail_o), eflag);
  endtask

  task automatic summary;
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", int'(res_valid_o), 0);
    chk("R1 max", int'(max_flips_o), 0);
    chk("R1 total", int'(total_corr_o), 0);
    chk("R1 fails", int'(fail_cnt_o), 0);
    chk("R1 flag", int'(page_fail_o), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 post", int'(res_valid_o) + int'(total_corr_o), 0);

    // R2: clean chunks only
    beat(1, 0, 1, 8'h00); beat(0, 0, 1, 8'h00); beat(0, 1, 1, 8'h00);
    finish_page("R2", 0, 0, 0, 0);

    // R6 with R3 erased in between; last status on page end (R10)
    beat(1, 0, 1, 8'd5); beat(0, 0, 1, 8'hFF); beat(0, 0, 1, 8'd3); beat(0, 1, 1, 8'd40);
    finish_page("R6", 40, 48, 0, 0);

    // R4 and R5: 0xFE and over-ceiling codes fail
    beat(1, 0, 1, 8'hFE); beat(0, 0, 1, 8'd7); beat(0, 0, 1, 8'hFD); beat(0, 1, 1, 8'h29);
    finish_page("R5", 7, 7, 3, 1);

    // R9: single-chunk page, start/end/status in one cycle
    beat(1, 1, 1, 8'd12);
    finish_page("R9", 12, 12, 0, 0);

    // R12: invalid bytes ignored
    beat(1, 0, 1, 8'd1); beat(0, 0, 0, 8'hFE); beat(0, 0, 0, 8'd39); beat(0, 1, 1, 8'd2);
    finish_page("R12", 2, 3, 0, 0);

    // R3: erased-only page
    beat(1, 0, 1, 8'hFF); beat(0, 0, 1, 8'hFF); beat(0, 1, 1, 8'hFF);
    finish_page("R3", 0, 0, 0, 0);

    // R10: outputs hold while idle
    repeat (3) begin
      @(negedge clk);
      chk("R10 hold strobe", int'(res_valid_o), 0);
      chk("R10 hold max", int'(max_flips_o), 0);
    end

    // R8: total saturation
    for (int i = 0; i < 1700; i++) beat(i == 0, i == 1699, 1, 8'd40);
    finish_page("R8", 40, 65535, 0, 0);

    // R11: failure count saturation
    for (int i = 0; i < 300; i++) beat(i == 0, i == 299, 1, 8'hFE);
    finish_page("R11", 0, 0, 255, 1);

    // R4: fresh page after saturation, a single 0xFE
    beat(1, 0, 1, 8'd9); beat(0, 1, 1, 8'hFE);
    finish_page("R4", 9, 9, 1, 1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule